// File: doc/BRIEF.md
# Random Table Update Engine

This block drives a sequence of pseudo-random read-modify-write updates into a table held in a local synchronous memory. A start pulse makes it write every table entry with its own index, one entry per cycle. It then runs a programmable number of update steps. Each step advances a 64-bit value register by one position of a shift-and-fold recurrence. It masks that value down to a table index, reads the entry, and writes back the old contents XORed with the value.

The engine owns the memory port for the whole run. Each update takes a read cycle and a write cycle to the same address, and the next step does not begin until that write has been issued. The table depth (2^IDX_W entries) and the fold polynomial are parameters. Each applied value/index pair is also presented on a stream output in the cycle its write happens. A done flag reports completion and stays set until the next start.

Top module: `rtu_engine`

## Requirements
- R1: While reset is asserted and after its release, done, mem_we, mem_re and upd_valid are all 0 until a start is accepted.
- R2: After an accepted start, the engine writes table entries 0, 1, ..., 2^IDX_W-1 in ascending order on consecutive cycles, each with write data equal to its own index zero-extended to 64 bits.
- R3: The value register is set to 1 on an accepted start. Each update step replaces it with the value shifted left by one bit, XORed with POLY when bit 63 of the old value is 1 and with 0 otherwise. The first value applied is therefore the successor of 1.
- R4: The table index of an update is the update value ANDed with 2^IDX_W-1, i.e. its low IDX_W bits.
- R5: Every update asserts mem_re for one cycle and then, in the very next cycle, mem_we at the same address. Read data is expected one cycle after mem_re, and the write data is that read data XORed with the update value.
- R6: Exactly upd_count updates, sampled at the accepted start, are performed. A count of zero performs the fill and no update.
- R7: done rises 2^IDX_W + 3*upd_count cycles after the clock edge that accepts start. It then stays 1 until a start is accepted again, and it is 0 in the cycle after that acceptance.
- R8: start is accepted only when the engine is idle or done. A start during the fill or update phases changes neither the write sequence nor the completion time.
- R9: upd_valid is 1 exactly in the write cycle of each update, with upd_value equal to the applied value and upd_index equal to the written address.
- R10: While idle or done, the engine makes no memory access (mem_we and mem_re are 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fill-and-update run (accepted when idle or done) |
| upd_count | input | CNT_W | Number of updates, sampled when start is accepted |
| done | output | 1 | Run finished; held until the next accepted start |
| mem_addr | output | IDX_W | Table address |
| mem_wdata | output | 64 | Table write data |
| mem_we | output | 1 | Table write enable |
| mem_re | output | 1 | Table read enable; data returns next cycle |
| mem_rdata | input | 64 | Table read data |
| upd_valid | output | 1 | An update value/index pair is being applied |
| upd_value | output | 64 | Applied update value |
| upd_index | output | IDX_W | Table index of the applied update |

## Verification
Checked on every cycle by the assertions: the read-then-write pairing at one address, the ascending fill addresses, a step never issued with no updates left, done holding until start, starts ignored while busy, the stream coinciding with a write, and a quiet memory port while done. Only the bench's scenarios can show the actual contents written: the exact recurrence including the fold into POLY after the value reaches bit 63, the masked indices, the XOR data against a modelled memory, the exact update count including zero, and the completion cycle.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  localparam int unsigned WORD_W = 64;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL,
    PH_STEP,
    PH_READ,
    PH_WRITE,
    PH_DONE
  } phase_e;

  // One step of the shift-and-fold recurrence.
  function automatic word_t rtu_advance(word_t cur, word_t poly);
    word_t fold;
    fold = cur[WORD_W-1] ? poly : '0;
    return {cur[WORD_W-2:0], 1'b0} ^ fold;
  endfunction

  // Seed loaded into the value register on every accepted start.
  function automatic word_t rtu_seed();
    return word_t'(1);
  endfunction
endpackage

// File: rtl/rtu_value_gen.sv
module rtu_value_gen
  import rtu_pkg::*;
#(
  parameter word_t POLY = 64'h7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  seed_load,
  input  logic  advance,
  output word_t value
);

  always_ff @(posedge clk) begin
    if (!rst_n)         value <= rtu_seed();
    else if (seed_load) value <= rtu_seed();
    else if (advance)   value <= rtu_advance(value, POLY);
  end

  // With an odd polynomial the recurrence never collapses to zero.
  if (POLY[0]) begin : g_nonzero_chk
    assert_value_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      value != '0);
  end

  // A loaded seed is not disturbed in the cycle it appears.
  assert_seed_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !advance);

endmodule

// File: rtl/rtu_ctrl.sv
module rtu_ctrl
  import rtu_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] upd_count,
  output phase_e           phase,
  output logic [IDX_W-1:0] fill_idx,
  output logic             seed_load,
  output logic             advance,
  output logic             done
);

  logic [CNT_W-1:0] remaining;
  phase_e           phase_nx;

  // Named internal events
  logic start_accept;
  logic fill_last;
  logic step_fire;
  logic upd_last;
  logic busy;

  assign busy         = (phase == PH_FILL) || (phase == PH_STEP) ||
                        (phase == PH_READ) || (phase == PH_WRITE);
  assign start_accept = start && !busy;
  assign fill_last    = (phase == PH_FILL) && (&fill_idx);
  assign step_fire    = (phase == PH_STEP);
  assign upd_last     = (phase == PH_WRITE) && (remaining == '0);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:  if (start_accept) phase_nx = PH_FILL;
      PH_FILL:  if (fill_last) phase_nx = (remaining == '0) ? PH_DONE : PH_STEP;
      PH_STEP:  phase_nx = PH_READ;
      PH_READ:  phase_nx = PH_WRITE;
      PH_WRITE: phase_nx = upd_last ? PH_DONE : PH_STEP;
      PH_DONE:  if (start_accept) phase_nx = PH_FILL;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      fill_idx  <= '0;
      remaining <= '0;
    end else begin
      phase <= phase_nx;
      if (start_accept)            fill_idx <= '0;
      else if (phase == PH_FILL)   fill_idx <= fill_idx + 1'b1;
      if (start_accept)            remaining <= upd_count;
      else if (step_fire)          remaining <= remaining - 1'b1;
    end
  end

  assign seed_load = start_accept;
  assign advance   = step_fire;
  assign done      = (phase == PH_DONE);

  assert_step_has_work_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> remaining != '0);

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);

  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && phase != PH_FILL) |=> phase != PH_FILL);

endmodule

// File: rtl/rtu_mem_port.sv
module rtu_mem_port
  import rtu_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  phase_e           phase,
  input  logic [IDX_W-1:0] fill_idx,
  input  word_t            value,
  input  word_t            rdata,
  output logic [IDX_W-1:0] addr,
  output word_t            wdata,
  output logic             we,
  output logic             re,
  output logic             strm_valid,
  output word_t            strm_value,
  output logic [IDX_W-1:0] strm_index
);

  localparam logic [IDX_W-1:0] IDX_MASK = {IDX_W{1'b1}};

  function automatic logic [IDX_W-1:0] table_index(word_t v);
    return v[IDX_W-1:0] & IDX_MASK;
  endfunction

  logic [IDX_W-1:0] upd_idx;
  assign upd_idx = table_index(value);

  always_comb begin
    addr  = upd_idx;
    wdata = rdata ^ value;
    we    = 1'b0;
    re    = 1'b0;
    unique case (phase)
      PH_FILL: begin
        addr  = fill_idx;
        wdata = word_t'(fill_idx);
        we    = 1'b1;
      end
      PH_READ:  re = 1'b1;
      PH_WRITE: we = 1'b1;
      default: ;
    endcase
  end

  assign strm_valid = (phase == PH_WRITE);
  assign strm_value = value;
  assign strm_index = upd_idx;

endmodule

// File: rtl/rtu_engine.sv
module rtu_engine
  import rtu_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned CNT_W = 32,
  parameter word_t       POLY  = 64'h7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] upd_count,
  output logic             done,
  output logic [IDX_W-1:0] mem_addr,
  output logic [63:0]      mem_wdata,
  output logic             mem_we,
  output logic             mem_re,
  input  logic [63:0]      mem_rdata,
  output logic             upd_valid,
  output logic [63:0]      upd_value,
  output logic [IDX_W-1:0] upd_index
);

  phase_e           phase;
  logic [IDX_W-1:0] fill_idx;
  logic             seed_load;
  logic             advance;
  word_t            value;

  rtu_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .upd_count (upd_count),
    .phase     (phase),
    .fill_idx  (fill_idx),
    .seed_load (seed_load),
    .advance   (advance),
    .done      (done)
  );

  rtu_value_gen #(.POLY(POLY)) u_value (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .advance   (advance),
    .value     (value)
  );

  rtu_mem_port #(.IDX_W(IDX_W)) u_port (
    .phase      (phase),
    .fill_idx   (fill_idx),
    .value      (value),
    .rdata      (mem_rdata),
    .addr       (mem_addr),
    .wdata      (mem_wdata),
    .we         (mem_we),
    .re         (mem_re),
    .strm_valid (upd_valid),
    .strm_value (upd_value),
    .strm_index (upd_index)
  );

  assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_we && mem_addr == $past(mem_addr)));

  assert_no_read_write_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  assert_fill_ascends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FILL && !(&mem_addr)) |=> (mem_we && mem_addr == $past(mem_addr) + 1'b1));

  assert_stream_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (mem_we && mem_addr == upd_index));

  assert_quiet_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_we && !mem_re && !upd_valid));

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!done && !mem_we && !mem_re));

endmodule

// File: tb/tb_rtu_engine.sv
module tb_rtu_engine;
  localparam int          IDX_W = 4;
  localparam int          DEPTH = 1 << IDX_W;
  localparam int          CNT_W = 16;
  localparam logic [63:0] POLY  = 64'h7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] upd_count = '0;
  logic             done;
  logic [IDX_W-1:0] mem_addr;
  logic [63:0]      mem_wdata;
  logic             mem_we;
  logic             mem_re;
  logic [63:0]      mem_rdata;
  logic             upd_valid;
  logic [63:0]      upd_value;
  logic [IDX_W-1:0] upd_index;

  always #5 clk = ~clk;

  rtu_engine #(.IDX_W(IDX_W), .CNT_W(CNT_W), .POLY(POLY)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .upd_count(upd_count), .done(done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .upd_valid(upd_valid), .upd_value(upd_value),
    .upd_index(upd_index)
  );

  // Behavioural memory: registered read data.
  logic [63:0] mem [DEPTH];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: queues of expected writes and stream pairs.
  logic [63:0] exp_waddr[$];
  logic [63:0] exp_wdata[$];
  logic [63:0] exp_sval[$];
  logic [63:0] exp_sidx[$];
  logic [63:0] shadow [DEPTH];

  function automatic logic [63:0] ref_next(logic [63:0] v);
    if ($signed(v) < 0) return (v << 1) ^ POLY;
    return v << 1;
  endfunction

  task automatic build_expected(int n);
    logic [63:0] v;
    int idx;
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = 64'(i);
      exp_waddr.push_back(64'(i));
      exp_wdata.push_back(64'(i));
    end
    v = 64'd1;
    for (int k = 0; k < n; k++) begin
      v = ref_next(v);
      idx = int'(v % DEPTH);
      shadow[idx] = shadow[idx] ^ v;
      exp_waddr.push_back(64'(idx));
      exp_wdata.push_back(shadow[idx]);
      exp_sval.push_back(v);
      exp_sidx.push_back(64'(idx));
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (mem_we) begin
        if (exp_waddr.size() == 0) begin
          chk(0, "R10 unexpected write", 64'(mem_addr), 64'hx);
        end else begin
          chk(64'(mem_addr) == exp_waddr[0], "R2/R4 write address", 64'(mem_addr), exp_waddr[0]);
          chk(mem_wdata == exp_wdata[0], "R3/R5 write data", mem_wdata, exp_wdata[0]);
          void'(exp_waddr.pop_front());
          void'(exp_wdata.pop_front());
        end
      end
      if (mem_re) begin
        if (exp_waddr.size() == 0) chk(0, "R10 unexpected read", 64'(mem_addr), 64'hx);
        else chk(64'(mem_addr) == exp_waddr[0], "R5 read address", 64'(mem_addr), exp_waddr[0]);
      end
      if (upd_valid) begin
        if (exp_sval.size() == 0) begin
          chk(0, "R9 unexpected stream", upd_value, 64'hx);
        end else begin
          chk(upd_value == exp_sval[0], "R9 stream value", upd_value, exp_sval[0]);
          chk(64'(upd_index) == exp_sidx[0], "R9 stream index", 64'(upd_index), exp_sidx[0]);
          void'(exp_sval.pop_front());
          void'(exp_sidx.pop_front());
        end
      end
    end
  end

  task automatic run(int n, int poke, string tag);
    int cycles;
    build_expected(n);
    @(negedge clk);
    upd_count = CNT_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, {"R7 done cleared after start ", tag}, 64'(done), 64'd0);
    cycles = 0;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
      start = (cycles == poke);
    end
    start = 1'b0;
    chk(cycles == DEPTH + 3 * n, {"R7/R8 completion cycle ", tag}, 64'(cycles), 64'(DEPTH + 3 * n));
    chk(exp_waddr.size() == 0, {"R6 all writes issued ", tag}, 64'(exp_waddr.size()), 64'd0);
    chk(exp_sval.size() == 0, {"R6/R9 all updates streamed ", tag}, 64'(exp_sval.size()), 64'd0);
    repeat (6) @(negedge clk);
    chk(done == 1'b1, {"R7 done held ", tag}, 64'(done), 64'd1);
    for (int i = 0; i < DEPTH; i++)
      chk(mem[i] == shadow[i], {"R5 final table ", tag}, mem[i], shadow[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0 && upd_valid == 1'b0,
        "R1 outputs in reset", {60'd0, done, mem_we, mem_re, upd_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 idle after reset",
        {61'd0, done, mem_we, mem_re}, 64'd0);

    run(5, -1, "short");        // R2 R3 R4 R5
    run(70, -1, "fold");        // R3: value passes bit 63 and folds POLY
    run(0, -1, "zero");         // R6: fill only
    run(3, 4, "poke-fill");     // R8: start during fill
    run(4, DEPTH + 5, "poke-upd"); // R8: start during updates

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule